// File: doc/BRIEF.md
# Display Controller Register Window Decoder

This block sits behind the memory-mapped register window of a VGA-compatible display controller. It takes single host accesses and sends each one to one of three back ends. The first is a legacy 8-bit I/O port range that is remapped into the window. The second is a mode-setting register file reached through an index port and a 16-bit data port. The third is a small extension bank that holds the framebuffer byte-order flag.

Each host access starts with a one-cycle read or write strobe. The block then runs the back-end transfers one per cycle and ends with a one-cycle `hostDone` pulse that carries the read data. A wide legacy write is split into byte writes from the lowest address up. A mode-setting access always loads the index before it touches the data port. Because of this ordering, a 16-bit write to an index/data port pair updates both in one host access.

The decoder has three sub-windows. The legacy sub-window starts at window offset 0x400 and is 0x20 bytes long. The mode-setting sub-window starts at 0x500 and is 0x17 bytes long. The extension bank starts at 0x600 and is 8 bytes long, and it is present only when `EXT_EN` is 1. The byte-order magic words are 0xBEBEBEBE for big-endian and 0x1E1E1E1E for little-endian.

Top module: `mmio_regwin`

## Requirements
- R1: After reset, `bigEndianFb`, `hostDone` and every back-end strobe are 0.
- R2: `hostSize` selects the access width: 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. A legacy write at sub-window offset N with B bytes makes B port writes, one per cycle. The k-th port write goes to port address 0x3C0+N+k and carries write-data bits [8k+7:8k], for k = 0 up to B-1 in ascending order.
- R3: A legacy read of B bytes reads ports 0x3C0+N to 0x3C0+N+B-1. The byte from port 0x3C0+N+k is placed at read-data bits [8k+7:8k], and all higher read-data bits are 0.
- R4: A mode-setting access at offset N makes one 16-bit transfer for sizes 0 and 1, and two transfers for size 2. For each transfer t, the block first loads index (N>>1)+t through `modeIdxWr`, then strobes the data port. Transfer t writes bits [16t+15:16t], or fills them when reading. A 1-byte write sends the low byte zero-extended to 16 bits, and a 1-byte read returns only the low 8 bits of the data port.
- R5: A 4-byte read of extension offset 0 returns the bank size, which is 8. A 4-byte read of any extension offset other than 0 and 4 returns 0.
- R6: A 4-byte write of 0xBEBEBEBE to extension offset 4 sets `bigEndianFb`, and a 4-byte write of 0x1E1E1E1E to that offset clears it. Any other value, and any write to another extension offset, leaves the flag as it was.
- R7: A 4-byte read of extension offset 4 returns 0xBEBEBEBE while `bigEndianFb` is 1 and 0x1E1E1E1E while it is 0.
- R8: An extension access that is not 4 bytes wide has no effect: it reads 0 and leaves the flag unchanged.
- R9: The following accesses are unmapped: an address outside all sub-windows, size code 3, and the extension range when `EXT_EN` is 0. An unmapped access reads 0, makes no back-end strobe and does not change the flag.
- R10: `hostDone` pulses for exactly one cycle, T+1 cycles after the strobe is sampled, where T is the number of back-end strobe cycles. T is B for a legacy access, 2 per 16-bit transfer for a mode-setting access, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | ADDR_W | Byte offset within the window |
| hostSize | input | 2 | Access width code (0: 1 B, 1: 2 B, 2: 4 B) |
| hostWdata | input | 32 | Write data, little-endian |
| hostRd | input | 1 | Read strobe, sampled when idle |
| hostWr | input | 1 | Write strobe, sampled when idle |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read data, valid with hostDone |
| portAddr | output | PORT_W | Legacy port address |
| portWdata | output | 8 | Legacy port write byte |
| portRd | output | 1 | Legacy port read strobe |
| portWr | output | 1 | Legacy port write strobe |
| portRdata | input | 8 | Legacy port read byte |
| modeIdxWr | output | 1 | Load mode-setting index from modeWdata |
| modeDataWr | output | 1 | Mode-setting data write strobe |
| modeDataRd | output | 1 | Mode-setting data read strobe |
| modeWdata | output | 16 | Index or data word |
| modeRdata | input | 16 | Mode-setting data read word |
| bigEndianFb | output | 1 | Framebuffer big-endian flag |

## Verification
The assertions assume three things about the host and the back ends. The host raises a strobe only while no access is in progress, and never raises read and write together. The back ends return read data in the same cycle as their read strobe. The bench meets these conditions in the following ways:
- Every access goes through a single task that waits for `hostDone`, plus one more cycle, before it issues the next strobe.
- The legacy port range and the indexed register file are modelled as bench memories that answer combinationally.

The sweeps cover every offset of the legacy and mode-setting sub-windows at every size. Expected port addresses, byte lanes, index values and latencies are computed arithmetically from the offset and size.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_LEGACY = 2'd1,
    RGN_MODE   = 2'd2,
    RGN_EXT    = 2'd3
  } region_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       latch;    // capture request fields
    logic       portRd;
    logic       portWr;
    logic       modeIdx;  // load index latch
    logic       modeRd;
    logic       modeWr;
    logic       extRd;
    logic       extWr;
    logic       done;
    logic [1:0] step;     // byte step (legacy) or {transfer, phase} (mode)
  } strobe_t;

  localparam logic [31:0] MAGIC_BIG    = 32'hBEBE_BEBE;
  localparam logic [31:0] MAGIC_LITTLE = 32'h1E1E_1E1E;

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFF_W     = 8,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SIZE  = 'h20,
  parameter int MODE_BASE = 'h500,
  parameter int MODE_SIZE = 'h17,
  parameter int EXT_BASE  = 'h600,
  parameter int EXT_SIZE  = 8,
  parameter bit EXT_EN    = 1'b1
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  output region_e           region,
  output logic [OFF_W-1:0]  offset
);

  int   addrI;
  logic legHit;
  logic modeHit;
  logic extHit;

  assign addrI   = int'(hostAddr);
  assign legHit  = (addrI >= LEG_BASE)  && (addrI < LEG_BASE + LEG_SIZE);
  assign modeHit = (addrI >= MODE_BASE) && (addrI < MODE_BASE + MODE_SIZE);

  generate
    if (EXT_EN) begin : g_ext
      assign extHit = (addrI >= EXT_BASE) && (addrI < EXT_BASE + EXT_SIZE)
                      && (hostSize == 2'd2);
    end else begin : g_noext
      assign extHit = 1'b0;
    end
  endgenerate

  always_comb begin
    region = RGN_NONE;
    offset = '0;
    if (hostSize != 2'd3) begin
      if (legHit) begin
        region = RGN_LEGACY;
        offset = OFF_W'(addrI - LEG_BASE);
      end else if (modeHit) begin
        region = RGN_MODE;
        offset = OFF_W'(addrI - MODE_BASE);
      end else if (extHit) begin
        region = RGN_EXT;
        offset = OFF_W'(addrI - EXT_BASE);
      end
    end
  end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic [1:0] hostSize,
  input  region_e    region,
  output strobe_t    strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e     state;
  region_e    rgnReg;
  logic       wrReg;
  logic [1:0] stepReg;
  logic [1:0] lastStep;
  logic [2:0] nSteps;
  logic       start;

  assign start = (state == ST_IDLE) && (hostRd || hostWr);

  // Back-end strobe cycles needed by the decoded request
  always_comb begin
    case (region)
      RGN_LEGACY: nSteps = 3'(1 << hostSize);
      RGN_MODE:   nSteps = (hostSize == 2'd2) ? 3'd4 : 3'd2;
      default:    nSteps = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rgnReg   <= RGN_NONE;
      wrReg    <= 1'b0;
      stepReg  <= '0;
      lastStep <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          rgnReg   <= region;
          wrReg    <= hostWr;
          stepReg  <= '0;
          lastStep <= 2'(nSteps - 3'd1);
          state    <= (nSteps == 3'd0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (stepReg == lastStep) state <= ST_DONE;
          else stepReg <= stepReg + 2'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb       = '0;
    strb.latch = start;
    strb.step  = stepReg;
    if (state == ST_RUN) begin
      if (rgnReg == RGN_LEGACY) begin
        strb.portRd = !wrReg;
        strb.portWr = wrReg;
      end else if (rgnReg == RGN_MODE) begin
        strb.modeIdx = !stepReg[0];
        strb.modeRd  = stepReg[0] && !wrReg;
        strb.modeWr  = stepReg[0] && wrReg;
      end
    end
    if (state == ST_DONE) begin
      strb.done  = 1'b1;
      strb.extRd = (rgnReg == RGN_EXT) && !wrReg;
      strb.extWr = (rgnReg == RGN_EXT) && wrReg;
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done);

  // R9: at most one back-end strobe in any cycle
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.portRd, strb.portWr, strb.modeIdx, strb.modeRd, strb.modeWr}));

  // R4: data port strobe always follows an index load
  a_r4_index_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.modeRd || strb.modeWr) |-> $past(strb.modeIdx));

  // R10: no new request is taken while a transfer is running
  a_r10_no_latch_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.portRd || strb.portWr || strb.modeIdx || strb.modeRd || strb.modeWr)
      |-> !strb.latch);

endmodule

// File: rtl/regwin_dpath.sv
module regwin_dpath
  import regwin_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFF_W     = 8,
  parameter int PORT_W    = 10,
  parameter int PORT_BASE = 'h3C0,
  parameter int LEG_SIZE  = 'h20,
  parameter int EXT_SIZE  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  output logic              hostDone,
  output logic [31:0]       hostRdata,
  output logic [PORT_W-1:0] portAddr,
  output logic [7:0]        portWdata,
  output logic              portRd,
  output logic              portWr,
  input  logic [7:0]        portRdata,
  output logic              modeIdxWr,
  output logic              modeDataWr,
  output logic              modeDataRd,
  output logic [15:0]       modeWdata,
  input  logic [15:0]       modeRdata,
  output logic              bigEndianFb
);

  localparam int PORT_LAST = PORT_BASE + LEG_SIZE + 2;

  logic [OFF_W-1:0] offReg;
  logic [31:0]      wdataReg;
  logic [1:0]       sizeReg;
  logic [31:0]      rdataReg;
  logic             flagReg;
  logic             xfer;
  logic [15:0]      modeIndex;
  logic [15:0]      modeWord;
  logic [15:0]      modeRead;
  logic [31:0]      extVal;

  assign xfer      = strb.step[1];
  assign modeIndex = 16'(offReg >> 1) + 16'(xfer);
  assign modeWord  = (sizeReg == 2'd0) ? {8'h00, wdataReg[7:0]}
                                       : wdataReg[{xfer, 4'b0000} +: 16];
  assign modeRead  = (sizeReg == 2'd0) ? {8'h00, modeRdata[7:0]} : modeRdata;

  assign portAddr   = PORT_W'(PORT_BASE) + PORT_W'(offReg) + PORT_W'(strb.step);
  assign portWdata  = wdataReg[{strb.step, 3'b000} +: 8];
  assign portRd     = strb.portRd;
  assign portWr     = strb.portWr;
  assign modeIdxWr  = strb.modeIdx;
  assign modeDataWr = strb.modeWr;
  assign modeDataRd = strb.modeRd;
  assign modeWdata  = strb.modeIdx ? modeIndex : modeWord;

  always_comb begin
    case (int'(offReg))
      0:       extVal = 32'(EXT_SIZE);
      4:       extVal = flagReg ? MAGIC_BIG : MAGIC_LITTLE;
      default: extVal = 32'h0;
    endcase
  end

  assign hostDone    = strb.done;
  assign hostRdata   = !strb.done ? 32'h0 : (strb.extRd ? extVal : rdataReg);
  assign bigEndianFb = flagReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offReg   <= '0;
      wdataReg <= '0;
      sizeReg  <= '0;
      rdataReg <= '0;
      flagReg  <= 1'b0;
    end else begin
      if (strb.latch) begin
        offReg   <= offset;
        wdataReg <= hostWdata;
        sizeReg  <= hostSize;
        rdataReg <= '0;
      end
      if (strb.portRd) rdataReg[{strb.step, 3'b000} +: 8] <= portRdata;
      if (strb.modeRd) rdataReg[{xfer, 4'b0000} +: 16] <= modeRead;
      if (strb.extWr && (int'(offReg) == 4)) begin
        if (wdataReg == MAGIC_BIG) flagReg <= 1'b1;
        else if (wdataReg == MAGIC_LITTLE) flagReg <= 1'b0;
      end
    end
  end

  // R6: flag moves only in an extension write cycle
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.extWr |=> $stable(bigEndianFb));

  // R2: port addresses stay within the remapped legacy range
  a_r2_port_range: assert property (@(posedge clk) disable iff (!rstN)
    (portRd || portWr) |-> (int'(portAddr) >= PORT_BASE && int'(portAddr) <= PORT_LAST));

  // R9: read data is zero outside the completion cycle
  a_r9_rdata_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (portRd || portWr || modeIdxWr || modeDataRd || modeDataWr) |-> hostRdata == 32'h0);

endmodule

// File: rtl/mmio_regwin.sv
module mmio_regwin
  import regwin_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PORT_W    = 10,
  parameter int PORT_BASE = 'h3C0,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SIZE  = 'h20,
  parameter int MODE_BASE = 'h500,
  parameter int MODE_SIZE = 'h17,
  parameter int EXT_BASE  = 'h600,
  parameter int EXT_SIZE  = 8,
  parameter bit EXT_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  input  logic              hostRd,
  input  logic              hostWr,
  output logic              hostDone,
  output logic [31:0]       hostRdata,
  output logic [PORT_W-1:0] portAddr,
  output logic [7:0]        portWdata,
  output logic              portRd,
  output logic              portWr,
  input  logic [7:0]        portRdata,
  output logic              modeIdxWr,
  output logic              modeDataWr,
  output logic              modeDataRd,
  output logic [15:0]       modeWdata,
  input  logic [15:0]       modeRdata,
  output logic              bigEndianFb
);

  localparam int OFF_W = 8;

  region_e          region;
  logic [OFF_W-1:0] offset;
  strobe_t          strb;

  regwin_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .LEG_BASE(LEG_BASE), .LEG_SIZE(LEG_SIZE),
    .MODE_BASE(MODE_BASE), .MODE_SIZE(MODE_SIZE),
    .EXT_BASE(EXT_BASE), .EXT_SIZE(EXT_SIZE), .EXT_EN(EXT_EN)
  ) u_decode (
    .hostAddr(hostAddr), .hostSize(hostSize),
    .region(region), .offset(offset)
  );

  regwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .hostSize(hostSize), .region(region), .strb(strb)
  );

  regwin_dpath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PORT_W(PORT_W),
    .PORT_BASE(PORT_BASE), .LEG_SIZE(LEG_SIZE), .EXT_SIZE(EXT_SIZE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .offset(offset),
    .hostSize(hostSize), .hostWdata(hostWdata),
    .hostDone(hostDone), .hostRdata(hostRdata),
    .portAddr(portAddr), .portWdata(portWdata),
    .portRd(portRd), .portWr(portWr), .portRdata(portRdata),
    .modeIdxWr(modeIdxWr), .modeDataWr(modeDataWr), .modeDataRd(modeDataRd),
    .modeWdata(modeWdata), .modeRdata(modeRdata),
    .bigEndianFb(bigEndianFb)
  );

endmodule

// File: tb/sim_mmio_regwin.sv
module sim_mmio_regwin;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;

  logic        done0, done1;
  logic [31:0] rdata0, rdata1;
  logic [9:0]  portAddr, portAddr1;
  logic [7:0]  portWdata, portWdata1;
  logic        portRd, portWr, portRd1, portWr1;
  logic [7:0]  portRdata;
  logic        modeIdxWr, modeDataWr, modeDataRd, mIdx1, mWr1, mRd1;
  logic [15:0] modeWdata, modeWdata1, modeRdata;
  logic        flag0, flag1;

  always #2 clk = ~clk;

  mmio_regwin u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostSize(hostSize),
    .hostWdata(hostWdata), .hostRd(hostRd), .hostWr(hostWr),
    .hostDone(done0), .hostRdata(rdata0),
    .portAddr(portAddr), .portWdata(portWdata), .portRd(portRd), .portWr(portWr),
    .portRdata(portRdata),
    .modeIdxWr(modeIdxWr), .modeDataWr(modeDataWr), .modeDataRd(modeDataRd),
    .modeWdata(modeWdata), .modeRdata(modeRdata), .bigEndianFb(flag0)
  );

  mmio_regwin #(.EXT_EN(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostSize(hostSize),
    .hostWdata(hostWdata), .hostRd(hostRd), .hostWr(hostWr),
    .hostDone(done1), .hostRdata(rdata1),
    .portAddr(portAddr1), .portWdata(portWdata1), .portRd(portRd1), .portWr(portWr1),
    .portRdata(8'h00),
    .modeIdxWr(mIdx1), .modeDataWr(mWr1), .modeDataRd(mRd1),
    .modeWdata(modeWdata1), .modeRdata(16'h0000), .bigEndianFb(flag1)
  );

  // Back-end models and transfer logs
  logic [7:0]  portMem [0:63];
  logic [15:0] modeMem [0:15];
  logic [15:0] idxLatch;
  logic [9:0]  pLogA [0:15];
  logic [7:0]  pLogD [0:15];
  logic [1:0]  mKind [0:15];
  logic [15:0] mVal  [0:15];
  int pLogN, mLogN, anyN;

  assign portRdata = portMem[6'(portAddr - 10'h3C0)];
  assign modeRdata = modeMem[idxLatch[3:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      pLogN <= 0; mLogN <= 0; anyN <= 0; idxLatch <= '0;
      for (int i = 0; i < 64; i++) portMem[i] <= 8'(i * 7 + 1);
      for (int i = 0; i < 16; i++) modeMem[i] <= 16'(i * 257);
    end else begin
      if (portRd || portWr || modeIdxWr || modeDataRd || modeDataWr) anyN <= anyN + 1;
      if (portWr) begin
        portMem[6'(portAddr - 10'h3C0)] <= portWdata;
        pLogA[pLogN % 16] <= portAddr;
        pLogD[pLogN % 16] <= portWdata;
        pLogN <= pLogN + 1;
      end
      if (modeIdxWr) begin
        idxLatch <= modeWdata;
        mKind[mLogN % 16] <= 2'd1; mVal[mLogN % 16] <= modeWdata; mLogN <= mLogN + 1;
      end
      if (modeDataWr) begin
        modeMem[idxLatch[3:0]] <= modeWdata;
        mKind[mLogN % 16] <= 2'd2; mVal[mLogN % 16] <= modeWdata; mLogN <= mLogN + 1;
      end
      if (modeDataRd) begin
        mKind[mLogN % 16] <= 2'd3; mVal[mLogN % 16] <= idxLatch; mLogN <= mLogN + 1;
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] r0,
                        output logic [31:0] r1, output int lat);
    hostAddr = a; hostSize = sz; hostWdata = wd; hostWr = wr; hostRd = !wr;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0; lat = 1;
    while (!done0 && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    r0 = rdata0; r1 = rdata1;
    @(negedge clk);
    chk("R10 done single pulse", 32'(done0), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r0, r1, pat, mask, word, expv;
    int lat, pb, mb, ab, nb, nx;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag after reset", 32'(flag0), 32'h0);
    chk("R1 done after reset", 32'(done0), 32'h0);
    chk("R1 strobes after reset",
        32'({portRd, portWr, modeIdxWr, modeDataRd, modeDataWr}), 32'h0);

    // R2 / R3 legacy sweep
    for (int off = 0; off < 32; off++) begin
      for (int sz = 0; sz < 3; sz++) begin
        nb   = 1 << sz;
        pat  = 32'h9E37_79B9 * 32'(off * 3 + sz + 1);
        mask = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 32'h1);
        pb = pLogN;
        access(1'b1, 12'(12'h400 + off), 2'(sz), pat, r0, r1, lat);
        chk("R10 legacy write latency", 32'(lat), 32'(nb + 1));
        chk("R2 legacy write count", 32'(pLogN - pb), 32'(nb));
        for (int k = 0; k < nb; k++) begin
          chk("R2 port address order", 32'(pLogA[(pb + k) % 16]), 32'(10'h3C0 + off + k));
          chk("R2 port byte lane", 32'(pLogD[(pb + k) % 16]), 32'(pat[8 * k +: 8]));
        end
        access(1'b0, 12'(12'h400 + off), 2'(sz), 32'h0, r0, r1, lat);
        chk("R3 legacy read data", r0, pat & mask);
        chk("R10 legacy read latency", 32'(lat), 32'(nb + 1));
      end
    end

    // R4 mode-setting sweep
    for (int off = 0; off < 23; off++) begin
      for (int sz = 0; sz < 3; sz++) begin
        nx  = (sz == 2) ? 2 : 1;
        pat = 32'h6C8E_9CF5 * 32'(off * 5 + sz + 3);
        mb = mLogN;
        access(1'b1, 12'(12'h500 + off), 2'(sz), pat, r0, r1, lat);
        chk("R10 mode write latency", 32'(lat), 32'(2 * nx + 1));
        chk("R4 mode write count", 32'(mLogN - mb), 32'(2 * nx));
        for (int t = 0; t < nx; t++) begin
          word = (sz == 0) ? {24'h0, pat[7:0]} : {16'h0, pat[16 * t +: 16]};
          chk("R4 index phase", 32'(mKind[(mb + 2 * t) % 16]), 32'd1);
          chk("R4 index value", 32'(mVal[(mb + 2 * t) % 16]), 32'((off >> 1) + t));
          chk("R4 data phase", 32'(mKind[(mb + 2 * t + 1) % 16]), 32'd2);
          chk("R4 data word", 32'(mVal[(mb + 2 * t + 1) % 16]), word);
        end
        mb = mLogN;
        access(1'b0, 12'(12'h500 + off), 2'(sz), 32'h0, r0, r1, lat);
        expv = (sz == 0) ? (pat & 32'hFF) : ((sz == 1) ? (pat & 32'hFFFF) : pat);
        chk("R4 mode read data", r0, expv);
        chk("R4 read index before data", 32'({mKind[mb % 16], mKind[(mb + 1) % 16]}), 32'h7);
      end
    end
    access(1'b1, 12'h504, 2'd1, 32'h0000_ABCD, r0, r1, lat);
    access(1'b0, 12'h504, 2'd0, 32'h0, r0, r1, lat);
    chk("R4 byte read masks high half", r0, 32'h0000_00CD);

    // R5 / R7 extension reads
    access(1'b0, 12'h600, 2'd2, 32'h0, r0, r1, lat);
    chk("R5 size register", r0, 32'd8);
    chk("R10 ext latency", 32'(lat), 32'd1);
    for (int o = 1; o < 8; o++) begin
      if (o != 4) begin
        access(1'b0, 12'(12'h600 + o), 2'd2, 32'h0, r0, r1, lat);
        chk("R5 undefined ext offset", r0, 32'h0);
      end
    end
    access(1'b0, 12'h604, 2'd2, 32'h0, r0, r1, lat);
    chk("R7 byte order reads little", r0, 32'h1E1E_1E1E);

    // R6 flag control
    access(1'b1, 12'h604, 2'd2, 32'hBEBE_BEBE, r0, r1, lat);
    chk("R6 big magic sets flag", 32'(flag0), 32'h1);
    access(1'b0, 12'h604, 2'd2, 32'h0, r0, r1, lat);
    chk("R7 byte order reads big", r0, 32'hBEBE_BEBE);
    access(1'b1, 12'h604, 2'd2, 32'h1234_5678, r0, r1, lat);
    chk("R6 other value keeps set", 32'(flag0), 32'h1);
    access(1'b1, 12'h600, 2'd2, 32'h1E1E_1E1E, r0, r1, lat);
    chk("R6 magic at other offset ignored", 32'(flag0), 32'h1);
    access(1'b1, 12'h604, 2'd2, 32'h1E1E_1E1E, r0, r1, lat);
    chk("R6 little magic clears flag", 32'(flag0), 32'h0);
    access(1'b1, 12'h604, 2'd2, 32'hBEBE_BEBF, r0, r1, lat);
    chk("R6 near-magic keeps clear", 32'(flag0), 32'h0);

    // R8 narrow extension access
    access(1'b1, 12'h604, 2'd1, 32'hBEBE_BEBE, r0, r1, lat);
    chk("R8 narrow write ignored", 32'(flag0), 32'h0);
    access(1'b0, 12'h600, 2'd0, 32'h0, r0, r1, lat);
    chk("R8 narrow read zero", r0, 32'h0);

    // R9 unmapped accesses
    ab = anyN;
    access(1'b0, 12'h000, 2'd2, 32'h0, r0, r1, lat); chk("R9 unmapped 0x000", r0, 32'h0);
    access(1'b0, 12'h3FF, 2'd0, 32'h0, r0, r1, lat); chk("R9 unmapped 0x3FF", r0, 32'h0);
    access(1'b0, 12'h420, 2'd1, 32'h0, r0, r1, lat); chk("R9 unmapped 0x420", r0, 32'h0);
    access(1'b0, 12'h517, 2'd1, 32'h0, r0, r1, lat); chk("R9 unmapped 0x517", r0, 32'h0);
    access(1'b0, 12'h608, 2'd2, 32'h0, r0, r1, lat); chk("R9 unmapped 0x608", r0, 32'h0);
    chk("R10 unmapped latency", 32'(lat), 32'd1);
    access(1'b1, 12'h400, 2'd3, 32'hFFFF_FFFF, r0, r1, lat);
    access(1'b0, 12'h500, 2'd3, 32'h0, r0, r1, lat); chk("R9 size code 3 read", r0, 32'h0);
    chk("R9 no back-end strobes", 32'(anyN - ab), 32'h0);
    access(1'b1, 12'h604, 2'd2, 32'hBEBE_BEBE, r0, r1, lat);
    chk("R9 ext disabled flag", 32'(flag1), 32'h0);
    chk("R6 enabled instance flag", 32'(flag0), 32'h1);
    access(1'b0, 12'h600, 2'd2, 32'h0, r0, r1, lat);
    chk("R9 ext disabled read", r1, 32'h0);
    chk("R5 enabled instance read", r0, 32'd8);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule